// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is an associative store of `ENTRIES` words, each `WIDTH` bits wide. A search presents an argument word and a mask word. Every stored word is compared against the argument at the same time. Only the bit positions where the mask holds 1 take part in the compare, so a cleared mask bit makes that position a don't-care. One cycle later the block returns a vector with one bit per entry, a hit flag, and the index of the lowest matching entry.

Writes carry data but no address. The block picks the lowest-numbered unoccupied entry, stores the word there, and reports which entry it used. When no entry is free it raises a full flag and refuses the write. Software or a neighbouring block frees an entry by naming its index, after which the entry no longer matches and becomes available for reuse.

Top module: `masked_cam`

## Requirements
- R1: After reset no entry is occupied, `full` is low, and `res_valid` and `put_done` are low.
- R2: A write accepted in cycle t stores `put_data` in the lowest-index unoccupied entry. In cycle t+1 `put_done` is high and `put_slot` gives that index.
- R3: A search strobed in cycle t sets `res_valid` high for exactly cycle t+1. In that cycle bit i of `res_match` is 1 exactly when entry i is occupied and `((stored ^ arg) & mask) == 0`.
- R4: Positions where the mask is 0 do not affect the compare. For example, with argument 10111111 and mask 11100000, the stored word 10000001 does not match and the stored word 10100001 does.
- R5: A mask of all zeros matches every occupied entry and no unoccupied one.
- R6: An unoccupied entry never sets its match bit, whatever the argument and the mask.
- R7: `res_hit` is 1 when any match bit is set. `res_index` is the lowest set match bit, and it is 0 when nothing matches.
- R8: `full` is high exactly when every entry is occupied. A write requested while `full` is high is dropped: `put_done` stays low and no stored entry changes.
- R9: Freeing index k in cycle t makes entry k unoccupied from cycle t+1. A later write reuses it if it is the lowest free index.
- R10: A write, a free and a search can all occur in the same cycle. The search sees the contents from before that cycle. The write and the free both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| find_req | input | 1 | Search strobe |
| find_arg | input | WIDTH | Argument word for the search |
| find_mask | input | WIDTH | Per-bit compare enable for the search |
| res_valid | output | 1 | Search result present (one-cycle pulse) |
| res_match | output | ENTRIES | Per-entry match vector |
| res_hit | output | 1 | At least one entry matched |
| res_index | output | IDX_W | Lowest matching entry, 0 on a miss |
| put_req | input | 1 | Write request (data only, no address) |
| put_data | input | WIDTH | Word to store |
| put_done | output | 1 | Previous-cycle write was accepted |
| put_slot | output | IDX_W | Entry that received the accepted write |
| full | output | 1 | Every entry is occupied |
| drop_req | input | 1 | Free-entry request |
| drop_index | input | IDX_W | Entry to free |

## Verification
The bench builds the block with its default 16 entries of 8 bits. With that size it can fill every entry, reach the full state, and refuse a write within a short run. Eight-bit words are wide enough to reproduce the three-bit masked example, with entries that differ only in bits outside the mask. Sixteen entries give the lowest-index logic, on both the allocation side and the result side, gaps to skip over. The bench creates those gaps when it frees entries in the middle and then refills them.

// File: rtl/cam_pkg.sv
package cam_pkg;

   // Bits needed to name one of n items, never less than one.
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/cam_first_set.sv
// Lowest-index set bit finder, shared by slot allocation and result encoding.
module cam_first_set #(
   parameter int unsigned N   = 16,
   parameter int unsigned IDX = cam_pkg::idx_bits(N)
) (
   input  logic [N-1:0]   vec,
   output logic           any,
   output logic [IDX-1:0] pos
);
   logic [N-1:0] below;   // some lower bit is set
   logic [N-1:0] first;   // one-hot lowest set bit

   assign below[0] = 1'b0;
   genvar gi;
   generate
      for (gi = 1; gi < N; gi++) begin : g_chain
         assign below[gi] = below[gi-1] | vec[gi-1];
      end
   endgenerate

   assign first = vec & ~below;
   assign any   = |vec;

   always_comb begin
      pos = '0;
      for (int i = 0; i < N; i++) begin
         if (first[i]) pos = pos | IDX'(i);
      end
   end

   always_comb begin
      assert ($onehot0(first))
         else $error("p_first_onehot_r7 violated");
   end
endmodule

// File: rtl/cam_array.sv
// Entry storage with occupancy bits and a fully parallel masked compare.
module cam_array #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned WIDTH   = 8,
   parameter int unsigned IDX     = cam_pkg::idx_bits(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX-1:0]     wr_slot,
   input  logic [WIDTH-1:0]   wr_word,
   input  logic               clr_en,
   input  logic [IDX-1:0]     clr_slot,
   input  logic [WIDTH-1:0]   arg,
   input  logic [WIDTH-1:0]   mask,
   output logic [ENTRIES-1:0] occupied,
   output logic [ENTRIES-1:0] hits
);
   genvar gi;
   generate
      for (gi = 0; gi < ENTRIES; gi++) begin : g_entry
         logic [WIDTH-1:0] word_q;
         logic             occ_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               occ_q  <= 1'b0;
               word_q <= '0;
            end else begin
               if (clr_en && clr_slot == IDX'(gi)) occ_q <= 1'b0;
               if (wr_en && wr_slot == IDX'(gi)) begin
                  occ_q  <= 1'b1;
                  word_q <= wr_word;
               end
            end
         end

         assign occupied[gi] = occ_q;
         assign hits[gi]     = occ_q && (((word_q ^ arg) & mask) == '0);
      end
   endgenerate

   p_wr_sets_occ_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> occupied[$past(wr_slot)]);

   p_clr_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(wr_en && wr_slot == clr_slot)) |=> !occupied[$past(clr_slot)]);
endmodule

// File: rtl/masked_cam.sv
module masked_cam #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned WIDTH   = 8,
   localparam int unsigned IDX_W  = cam_pkg::idx_bits(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               find_req,
   input  logic [WIDTH-1:0]   find_arg,
   input  logic [WIDTH-1:0]   find_mask,
   output logic               res_valid,
   output logic [ENTRIES-1:0] res_match,
   output logic               res_hit,
   output logic [IDX_W-1:0]   res_index,
   input  logic               put_req,
   input  logic [WIDTH-1:0]   put_data,
   output logic               put_done,
   output logic [IDX_W-1:0]   put_slot,
   output logic               full,
   input  logic               drop_req,
   input  logic [IDX_W-1:0]   drop_index
);
   localparam logic [ENTRIES-1:0] ONE = 1;

   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("masked_cam: ENTRIES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("masked_cam: WIDTH must be at least 1");
      end
   endgenerate

   logic [ENTRIES-1:0] occupied, hits;
   logic               free_any, hit_any, accept;
   logic [IDX_W-1:0]   free_pos, hit_pos;

   cam_first_set #(.N(ENTRIES), .IDX(IDX_W)) u_alloc (
      .vec(~occupied), .any(free_any), .pos(free_pos));

   cam_first_set #(.N(ENTRIES), .IDX(IDX_W)) u_resolve (
      .vec(hits), .any(hit_any), .pos(hit_pos));

   assign full   = ~free_any;
   assign accept = put_req & free_any;

   cam_array #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .IDX(IDX_W)) u_array (
      .clk(clk), .rst_n(rst_n),
      .wr_en(accept), .wr_slot(free_pos), .wr_word(put_data),
      .clr_en(drop_req), .clr_slot(drop_index),
      .arg(find_arg), .mask(find_mask),
      .occupied(occupied), .hits(hits));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_match <= '0;
         res_hit   <= 1'b0;
         res_index <= '0;
         put_done  <= 1'b0;
         put_slot  <= '0;
      end else begin
         res_valid <= find_req;
         if (find_req) begin
            res_match <= hits;
            res_hit   <= hit_any;
            res_index <= hit_any ? hit_pos : '0;
         end
         put_done <= accept;
         if (accept) put_slot <= free_pos;
      end
   end

   p_result_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      find_req |=> res_valid);
   p_no_spurious_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !find_req |=> !res_valid);
   p_hit_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_hit == (res_match != '0)));
   p_index_lowest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> (res_match[res_index] && ((res_match & ((ONE << res_index) - ONE)) == '0)));
   p_match_occupied_r6: assert property (@(posedge clk) disable iff (!rst_n)
      find_req |=> ((res_match & ~$past(occupied)) == '0));
   p_full_rejects_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (put_req && full) |=> !put_done);
endmodule

// File: tb/tb_masked_cam.sv
module tb_masked_cam;
   localparam int unsigned ENT = 16;
   localparam int unsigned W   = 8;
   localparam int unsigned IW  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          find_req = 1'b0;
   logic [W-1:0]  find_arg = '0, find_mask = '0;
   logic          res_valid, res_hit, put_done, full;
   logic [ENT-1:0] res_match;
   logic [IW-1:0] res_index, put_slot;
   logic          put_req = 1'b0;
   logic [W-1:0]  put_data = '0;
   logic          drop_req = 1'b0;
   logic [IW-1:0] drop_index = '0;

   int unsigned n_run = 0, n_fail = 0;
   bit          finished = 0;

   logic [W-1:0] m_word [ENT];
   bit           m_occ  [ENT];

   always #5 clk = ~clk;

   masked_cam #(.ENTRIES(ENT), .WIDTH(W)) dut (
      .clk, .rst_n, .find_req, .find_arg, .find_mask, .res_valid, .res_match,
      .res_hit, .res_index, .put_req, .put_data, .put_done, .put_slot, .full,
      .drop_req, .drop_index);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [ENT-1:0] model_match(input logic [W-1:0] a, input logic [W-1:0] k);
      logic [ENT-1:0] v = '0;
      for (int i = 0; i < ENT; i++)
         v[i] = m_occ[i] && (((m_word[i] ^ a) & k) == '0);
      return v;
   endfunction

   function automatic int lowest_free();
      for (int i = 0; i < ENT; i++) if (!m_occ[i]) return i;
      return -1;
   endfunction

   task automatic check_result(input string req, input logic [ENT-1:0] exp);
      int lo = 0;
      for (int i = ENT - 1; i >= 0; i--) if (exp[i]) lo = i;
      check({req, " valid"}, 32'(res_valid), 32'd1);
      check({req, " vector"}, 32'(res_match), 32'(exp));
      check({req, " hit"}, 32'(res_hit), 32'(exp != '0));
      check({req, " index"}, 32'(res_index), 32'(lo));
   endtask

   task automatic do_search(input string req, input logic [W-1:0] a, input logic [W-1:0] k);
      logic [ENT-1:0] exp = model_match(a, k);
      @(negedge clk);
      find_req = 1'b1; find_arg = a; find_mask = k;
      @(negedge clk);
      find_req = 1'b0;
      check_result(req, exp);
   endtask

   task automatic do_write(input string req, input logic [W-1:0] d);
      int slot = lowest_free();
      @(negedge clk);
      put_req = 1'b1; put_data = d;
      @(negedge clk);
      put_req = 1'b0;
      if (slot < 0) begin
         check({req, " rejected"}, 32'(put_done), 32'd0);
      end else begin
         m_occ[slot] = 1; m_word[slot] = d;
         check({req, " done"}, 32'(put_done), 32'd1);
         check({req, " slot"}, 32'(put_slot), 32'(slot));
      end
   endtask

   task automatic do_drop(input int idx);
      @(negedge clk);
      drop_req = 1'b1; drop_index = IW'(idx);
      @(negedge clk);
      drop_req = 1'b0;
      m_occ[idx] = 0;
   endtask

   task automatic t_reset();
      for (int i = 0; i < ENT; i++) begin m_occ[i] = 0; m_word[i] = '0; end
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 full", 32'(full), 32'd0);
      check("R1 res_valid", 32'(res_valid), 32'd0);
      check("R1 put_done", 32'(put_done), 32'd0);
      rst_n = 1'b1;
      do_search("R1 empty", 8'h00, 8'h00);
   endtask

   task automatic t_fill();
      do_write("R2 w0", 8'b1000_0001);
      do_write("R2 w1", 8'b1010_0001);
      for (int i = 2; i < ENT; i++) begin
         do_write("R2 wn", W'(8'h40 + i));
         check("R8 full level", 32'(full), 32'(i == ENT - 1));
      end
   endtask

   task automatic t_full_reject();
      do_write("R8 write while full", 8'hEE);
      check("R8 full stays", 32'(full), 32'd1);
      do_search("R8 no trace of rejected word", 8'hEE, 8'hFF);
   endtask

   task automatic t_masked();
      do_search("R4 example", 8'b1011_1111, 8'b1110_0000);
      do_search("R3 exact", 8'h47, 8'hFF);
      do_search("R3 low nibble", 8'h05, 8'h0F);
      do_search("R7 miss", 8'hFF, 8'hFF);
      do_search("R5 mask zero", 8'h5A, 8'h00);
   endtask

   task automatic t_drop_reuse();
      do_drop(5);
      do_drop(1);
      check("R9 not full", 32'(full), 32'd0);
      do_search("R6 freed entries", 8'h00, 8'h00);
      do_search("R6 freed word", 8'b1010_0001, 8'hFF);
      do_write("R9 reuse low", 8'h91);
      do_write("R9 reuse next", 8'h95);
      do_search("R7 lowest of many", 8'h90, 8'hF0);
   endtask

   task automatic t_same_cycle();
      logic [ENT-1:0] exp;
      do_drop(7);
      exp = model_match(8'h00, 8'h00);
      @(negedge clk);
      put_req = 1'b1; put_data = 8'h33;
      drop_req = 1'b1; drop_index = IW'(2);
      find_req = 1'b1; find_arg = 8'h00; find_mask = 8'h00;
      @(negedge clk);
      put_req = 1'b0; drop_req = 1'b0; find_req = 1'b0;
      check_result("R10 search sees old", exp);
      check("R10 write done", 32'(put_done), 32'd1);
      check("R10 write slot", 32'(put_slot), 32'd7);
      m_occ[7] = 1; m_word[7] = 8'h33; m_occ[2] = 0;
      do_search("R10 after both", 8'h00, 8'h00);
   endtask

   initial begin
      t_reset();
      t_fill();
      t_full_reject();
      t_masked();
      t_drop_reuse();
      t_same_cycle();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule